// File: doc/BRIEF.md
# Bounded Symbol Timing Offset Controller

This block keeps the timing offset that a receive sample interpolator applies to each symbol. The offset is a signed count of eighth-chip steps. It is hard-limited to a fixed span on each side of nominal, so the receiver can follow a timing drift only for a limited time. At the start of each packet the offset and both internal accumulators return to zero.

The block has two ways to derive steps. In direct mode it adds up an early-minus-late timing error over the symbols. Each time the sum reaches a threshold, the block takes one step and clears the sum. In locked-oscillator mode it ignores the timing error. It accumulates a scaled carrier frequency offset once per symbol and takes a step each time that accumulator wraps past a modulus. This mode is valid only when both radios run their bit clock and their carrier from a common crystal. Locked-oscillator mode is chosen only when three bits are all set: the locked-clock flag received in the packet header, a matching local configuration bit, and a feature enable.

Top module: `sym_timing_ctrl`

## Requirements
- R1: After reset or a `pkt_start` pulse, `step_ofs` is 0, `at_limit` is 0, and both accumulators are empty.
- R2: In direct mode, on a symbol where the accumulated error plus `tim_err` is at least `ERR_TH` (default 64), `step_ofs` rises by 1 and the error accumulator clears to 0.
- R3: In direct mode, on a symbol where the accumulated error plus `tim_err` is at most −`ERR_TH`, `step_ofs` falls by 1 and the error accumulator clears to 0.
- R4: In direct mode, a symbol whose sum stays strictly between −`ERR_TH` and +`ERR_TH` leaves `step_ofs` unchanged and keeps the sum for the next symbol.
- R5: `locked_mode` is 1 only when `lock_en`, `svc_lock` and `cfg_lock` are all 1. Otherwise `freq_ofs` has no effect on `step_ofs`.
- R6: In locked mode, on a symbol where the drift accumulator plus `freq_ofs` is at least `DRIFT_WRAP` (default 1024), `step_ofs` rises by 1 and the accumulator keeps the sum minus `DRIFT_WRAP`.
- R7: In locked mode, on a symbol where that sum is at most −`DRIFT_WRAP`, `step_ofs` falls by 1 and the accumulator keeps the sum plus `DRIFT_WRAP`.
- R8: `step_ofs` never leaves the range −`STEP_LIMIT` to +`STEP_LIMIT` (default 72). A step that would move it past that range is discarded.
- R9: `at_limit` is 1 exactly while `step_ofs` equals +`STEP_LIMIT` or −`STEP_LIMIT`.
- R10: When `pkt_start` and `sym_valid` are both high in the same cycle, the clear wins and the symbol is dropped.
- R11: `step_ofs` changes only on a cycle with `sym_valid` or `pkt_start` high, and a symbol moves it by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Synchronous clear at the start of a packet |
| sym_valid | input | 1 | One-cycle strobe per symbol |
| tim_err | input | ERR_W | Signed early-minus-late timing error |
| freq_ofs | input | FREQ_W | Signed scaled carrier frequency offset |
| svc_lock | input | 1 | Locked-clock flag received in the header |
| cfg_lock | input | 1 | Local locked-clock configuration bit |
| lock_en | input | 1 | Enable for locked-oscillator tracking |
| step_ofs | output | OFS_W | Signed offset in eighth-chip steps |
| at_limit | output | 1 | Offset is at either end of its range |
| locked_mode | output | 1 | Locked-oscillator mode is active |

## Verification
Two events can land in the same cycle. One is a packet-start clear. The other is a symbol whose error would push the accumulator over the threshold. To provoke the collision, the bench first loads the error accumulator to 40 and then raises `pkt_start` together with a symbol carrying an error of 30. Taken alone, that symbol would cause a step. The bench judges the outcome from the ports. It checks that `step_ofs` stays 0. It then sends a second symbol with an error of 30 and checks that `step_ofs` is still 0, which shows that the old partial sum was cleared and was not carried forward. A second collision appears at the range edge: the bench checks that a step pushing outward at ±72 leaves both the offset and `at_limit` unchanged.

// File: rtl/sym_timing_ctrl.sv
module sym_timing_ctrl #(
  parameter int STEP_LIMIT = 72,
  parameter int ERR_W      = 8,
  parameter int ERR_TH     = 64,
  parameter int FREQ_W     = 12,
  parameter int DRIFT_WRAP = 1024,
  localparam int OFS_W = $clog2(STEP_LIMIT + 1) + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pkt_start,
  input  logic                     sym_valid,
  input  logic signed [ERR_W-1:0]  tim_err,
  input  logic signed [FREQ_W-1:0] freq_ofs,
  input  logic                     svc_lock,
  input  logic                     cfg_lock,
  input  logic                     lock_en,
  output logic signed [OFS_W-1:0]  step_ofs,
  output logic                     at_limit,
  output logic                     locked_mode
);

  localparam int EA_W = ((ERR_W > $clog2(ERR_TH)) ? ERR_W : $clog2(ERR_TH)) + 2;
  localparam int DA_W = ((FREQ_W > $clog2(DRIFT_WRAP)) ? FREQ_W : $clog2(DRIFT_WRAP)) + 2;
  localparam logic signed [EA_W-1:0]  TH_P  = EA_W'(ERR_TH);
  localparam logic signed [EA_W-1:0]  TH_N  = -TH_P;
  localparam logic signed [DA_W-1:0]  WR_P  = DA_W'(DRIFT_WRAP);
  localparam logic signed [DA_W-1:0]  WR_N  = -WR_P;
  localparam logic signed [OFS_W-1:0] LIM_P = OFS_W'(STEP_LIMIT);
  localparam logic signed [OFS_W-1:0] LIM_N = -LIM_P;

  logic signed [EA_W-1:0]  ea_q, ea_sum, ea_nxt;
  logic signed [DA_W-1:0]  da_q, da_sum, da_nxt;
  logic signed [1:0]       step;
  logic signed [OFS_W-1:0] ofs_try;

  assign locked_mode = lock_en & svc_lock & cfg_lock;
  assign ea_sum  = ea_q + {{(EA_W-ERR_W){tim_err[ERR_W-1]}}, tim_err};
  assign da_sum  = da_q + {{(DA_W-FREQ_W){freq_ofs[FREQ_W-1]}}, freq_ofs};
  assign ofs_try = step_ofs + {{(OFS_W-2){step[1]}}, step};
  assign at_limit = (step_ofs == LIM_P) || (step_ofs == LIM_N);

  always_comb begin
    step   = 2'sd0;
    ea_nxt = ea_q;
    da_nxt = da_q;
    if (locked_mode) begin
      if (da_sum >= WR_P) begin
        step   = 2'sd1;
        da_nxt = da_sum - WR_P;
      end else if (da_sum <= WR_N) begin
        step   = -2'sd1;
        da_nxt = da_sum + WR_P;
      end else begin
        da_nxt = da_sum;
      end
    end else begin
      if (ea_sum >= TH_P) begin
        step   = 2'sd1;
        ea_nxt = '0;
      end else if (ea_sum <= TH_N) begin
        step   = -2'sd1;
        ea_nxt = '0;
      end else begin
        ea_nxt = ea_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q     <= '0;
      da_q     <= '0;
      step_ofs <= '0;
    end else if (pkt_start) begin
      ea_q     <= '0;
      da_q     <= '0;
      step_ofs <= '0;
    end else if (sym_valid) begin
      ea_q <= ea_nxt;
      da_q <= da_nxt;
      if (ofs_try <= LIM_P && ofs_try >= LIM_N)
        step_ofs <= ofs_try;
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> (step_ofs == '0) && !at_limit);  // R10
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ofs <= LIM_P) && (step_ofs >= LIM_N));  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && !pkt_start) |=> $stable(step_ofs));  // R11
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !pkt_start) |=> ((step_ofs - $past(step_ofs)) <= 1) && (($past(step_ofs) - step_ofs) <= 1));  // R11
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_start && step_ofs == LIM_P) |=> step_ofs >= LIM_P - 1);  // R9
  AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !pkt_start && !locked_mode && tim_err == '0 && ea_q == '0) |=> $stable(step_ofs));  // R5

endmodule

// File: tb/sym_timing_ctrl_test.sv
`timescale 1ns/1ps
module sym_timing_ctrl_test;
  logic clk = 0, rst_n = 0, pkt_start = 0, sym_valid = 0;
  logic signed [7:0]  tim_err = 0;
  logic signed [11:0] freq_ofs = 0;
  logic svc_lock = 0, cfg_lock = 0, lock_en = 0;
  logic signed [8:0] step_ofs;
  logic at_limit, locked_mode;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sym_timing_ctrl uut (.clk, .rst_n, .pkt_start, .sym_valid, .tim_err, .freq_ofs,
    .svc_lock, .cfg_lock, .lock_en, .step_ofs, .at_limit, .locked_mode);

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic sym(int e, int f);
    @(negedge clk);
    sym_valid = 1; tim_err = 8'(e); freq_ofs = 12'(f);
    @(negedge clk);
    sym_valid = 0; tim_err = 0; freq_ofs = 0;
  endtask

  task automatic clear();
    @(negedge clk); pkt_start = 1;
    @(negedge clk); pkt_start = 0;
  endtask

  task automatic t_reset();
    chk("R1 offset after reset", int'(step_ofs), 0);
    chk("R1 limit after reset", int'(at_limit), 0);
  endtask

  task automatic t_direct();
    clear();
    sym(40, 0);  chk("R4 below threshold", int'(step_ofs), 0);
    sym(30, 0);  chk("R2 positive crossing", int'(step_ofs), 1);
    sym(40, 0);  chk("R2 accumulator cleared", int'(step_ofs), 1);
    @(negedge clk); tim_err = 8'sd100; @(negedge clk); @(negedge clk); tim_err = 0;
    chk("R11 no symbol no step", int'(step_ofs), 1);
    clear();
    sym(-64, 0); chk("R3 negative exact threshold", int'(step_ofs), -1);
    sym(-63, 0); chk("R4 just inside threshold", int'(step_ofs), -1);
    sym(-1, 0);  chk("R3 second crossing", int'(step_ofs), -2);
  endtask

  task automatic t_mode();
    clear();
    svc_lock = 1; cfg_lock = 1; lock_en = 0;
    @(negedge clk); chk("R5 mode needs enable", int'(locked_mode), 0);
    sym(0, 1023); sym(0, 1023);
    chk("R5 freq ignored when disabled", int'(step_ofs), 0);
    lock_en = 1; cfg_lock = 0;
    @(negedge clk); chk("R5 mode needs cfg bit", int'(locked_mode), 0);
    cfg_lock = 1;
    @(negedge clk); chk("R5 mode all set", int'(locked_mode), 1);
    clear();
    sym(100, 0); chk("R5 timing error ignored in locked mode", int'(step_ofs), 0);
  endtask

  task automatic t_locked();
    clear();
    sym(0, 300); sym(0, 300); sym(0, 300);
    chk("R6 no wrap yet", int'(step_ofs), 0);
    sym(0, 300); chk("R6 overflow step", int'(step_ofs), 1);
    sym(0, 847); chk("R6 remainder kept below wrap", int'(step_ofs), 1);
    sym(0, 1);   chk("R6 remainder reaches wrap", int'(step_ofs), 2);
    clear();
    sym(0, -512); chk("R7 half wrap", int'(step_ofs), 0);
    sym(0, -512); chk("R7 underflow step", int'(step_ofs), -1);
    svc_lock = 0; cfg_lock = 0; lock_en = 0;
  endtask

  task automatic t_limit();
    clear();
    for (int i = 0; i < 71; i++) sym(64, 0);
    chk("R9 one short of limit", int'(at_limit), 0);
    sym(64, 0);
    chk("R8 reaches top", int'(step_ofs), 72);
    chk("R9 flag at top", int'(at_limit), 1);
    sym(64, 0);
    chk("R8 step past top discarded", int'(step_ofs), 72);
    chk("R9 flag held", int'(at_limit), 1);
    sym(-64, 0);
    chk("R9 flag drops", int'(at_limit), 0);
    chk("R8 back inside", int'(step_ofs), 71);
    clear();
    for (int i = 0; i < 74; i++) sym(-64, 0);
    chk("R8 bottom saturates", int'(step_ofs), -72);
    chk("R9 flag at bottom", int'(at_limit), 1);
    clear();
    chk("R1 packet start clears", int'(step_ofs), 0);
    chk("R1 packet start clears flag", int'(at_limit), 0);
  endtask

  task automatic t_collide();
    clear();
    sym(40, 0);
    @(negedge clk);
    pkt_start = 1; sym_valid = 1; tim_err = 8'sd30;
    @(negedge clk);
    pkt_start = 0; sym_valid = 0; tim_err = 0;
    chk("R10 clear wins over step", int'(step_ofs), 0);
    sym(30, 0);
    chk("R10 old sum discarded", int'(step_ofs), 0);
  endtask

  initial begin
    #20000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_mode();
    t_locked();
    t_limit();
    t_collide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule